// File: doc/BRIEF.md
# Command Frame Receiver with CRC-16

This block sits behind a host serial link and turns a stream of received bytes into decoded command frames. Each byte arrives on a valid/ready input. A frame opens with an INIT byte that gives the command type and, for writes, the payload length. A device address byte follows, but only for single-device commands. After that come a register address of two bytes, a data field and a two-byte CRC. A separate idle strobe marks a gap on the line. A gap in the middle of a frame makes the parser start over and wait for a new INIT byte.

A CRC-16 runs over every frame, and the receiver checks it before any other test. A frame that passes the CRC is offered on a valid/ready output. That output carries the command type, the clamped device address, the register address, the read count or the write payload. Two error pulses report a CRC mismatch and an INIT byte that cannot be decoded. A write aimed at a register outside the valid range is dropped without any report.

Back-pressure works as follows. The block holds one decoded frame at a time. While `out_valid` is high and `out_ready` is low, every output field stays stable and `in_ready` is low, so no byte is taken in. `in_ready` goes high again in the cycle after the frame is handed over. Senders must keep `in_data` stable while `in_valid` is high and `in_ready` is low.

Top module: `cmd_frame_rx`

## Requirements
- R1: INIT encoding. Bit 7 must be 1. Bits 6:4 give the kind: 0 single read, 1 single write, 2 stack read, 3 stack write, 4 broadcast read, 5 broadcast write. Bits 2:0 give the write length minus one; reads ignore them. Bit 3 has no effect. `out_kind` reports bits 6:4, and `out_write` is 1 for the odd kinds.
- R2: The register address is the two bytes that follow the INIT byte, or that follow the device address byte when one is present. The high byte comes first. It is reported on `out_reg`.
- R3: Only kinds 0 and 1 carry a device address byte. When bits 7:6 of that byte are nonzero, `out_dev` reports 0x3F; otherwise it reports bits 5:0. For every other kind `out_dev` is 0.
- R4: A read carries one data byte. `out_rd_cnt` equals bits 6:0 of that byte plus one, so it runs from 1 to 128, and bit 7 is ignored (0x99 gives 26). On a write, `out_rd_cnt` is 0.
- R5: A write carries 1 to 8 payload bytes. Payload byte i appears on `out_payload[8i+7:8i]`, unused lanes read 0, and `out_wr_len` gives the byte count. On a read, `out_wr_len` is 0.
- R6: The CRC is a bit-reflected CRC-16 with polynomial x^16+x^15+x^2+1 (reflected constant 0xA001) and seed 0xFFFF. It covers every byte from INIT through the last data byte and is sent low byte first. A frame is accepted only if the CRC run over the whole frame, CRC bytes included, leaves zero.
- R7: On a CRC mismatch, `err_crc` pulses for one cycle right after the last CRC byte is taken, and no frame is offered. This happens even when the register address is invalid.
- R8: An INIT byte with bit 7 at 0, or with kind 6 or 7, makes `err_init` pulse for one cycle. Every byte after it is then ignored until `in_idle` is seen.
- R9: `in_idle` high in the middle of a frame discards the partial frame, and the next byte taken is treated as INIT.
- R10: A write whose register address is REG_SPAN or higher is dropped with no `out_valid` and no error pulse. A read to such an address is still offered.
- R11: After reset, `out_valid` is 0, `in_ready` is 1 and the error pulses are 0. While `out_valid` is 1 and `out_ready` is 0, the frame and its fields stay unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the link |
| in_ready | output | 1 | Receiver can take a byte |
| in_data | input | 8 | Received byte |
| in_idle | input | 1 | Line idle, resets the parser |
| out_valid | output | 1 | Decoded frame available |
| out_ready | input | 1 | Consumer takes the frame |
| out_kind | output | 3 | Command kind (INIT bits 6:4) |
| out_write | output | 1 | Frame is a write |
| out_dev | output | 6 | Device address after clamping |
| out_reg | output | 16 | Register address |
| out_rd_cnt | output | 8 | Registers to read, 1 to 128 |
| out_wr_len | output | 4 | Write payload bytes, 1 to 8 |
| out_payload | output | 64 | Write payload, byte 0 in the low lane |
| err_crc | output | 1 | One-cycle CRC mismatch pulse |
| err_init | output | 1 | One-cycle bad INIT pulse |

## Verification
Single-device reads are swept over all 256 address bytes, which separates the clamp range from the pass-through range. Stack reads are swept over all 256 count bytes, which exposes any dependence on bit 7 and any off-by-one error in the count. Writes of every length in each write kind show whether the payload lanes and lengths line up. Every bit of every byte after INIT is flipped in turn, which must always produce a CRC fault and never a frame. Further cases check the ordering of CRC against register validity, bad INIT bytes followed by a well-formed frame, an idle gap inside a frame, and a stalled consumer.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int WR_MAX = 8;
  localparam int LEN_W = $clog2(WR_MAX);
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
  localparam logic [5:0] DEV_TOP = 6'h3F;
  localparam logic [2:0] KIND_LAST = 3'd5;

  typedef enum logic [2:0] {
    S_INIT, S_DEV, S_RA_HI, S_RA_LO, S_DATA, S_CRC_LO, S_CRC_HI, S_SKIP
  } rx_state_e;

  typedef struct packed {
    logic ok;
    logic is_write;
    logic has_dev;
    logic [2:0] kind;
    logic [LEN_W-1:0] len_m1;
  } init_info_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/cfr_init_decode.sv
module cfr_init_decode
  import cfr_pkg::*;
(
  input  logic             mark,
  input  logic [2:0]       kind,
  input  logic [LEN_W-1:0] len_m1,
  output init_info_t       info
);
  always_comb begin
    info.kind     = kind;
    info.len_m1   = len_m1;
    info.is_write = kind[0];
    info.has_dev  = (kind[2:1] == 2'b00);
    info.ok       = mark && (kind <= KIND_LAST);
  end
endmodule

// File: rtl/cfr_crc16.sv
module cfr_crc16
  import cfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        first,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc_nx
);
  logic [15:0] crc_q;

  assign crc_nx = crc16_byte(first ? CRC_SEED : crc_q, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nx;
  end

  // R6: the running remainder only moves on an accepted byte
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q)) else $error("crc moved without a byte");
endmodule

// File: rtl/cfr_parser.sv
module cfr_parser
  import cfr_pkg::*;
#(
  parameter int unsigned REG_SPAN = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  input  logic                 in_idle,
  input  logic                 out_ready,
  input  init_info_t           info,
  input  logic [15:0]          crc_nx,
  output logic                 in_ready,
  output logic                 crc_take,
  output logic                 crc_first,
  output logic                 out_valid,
  output logic [2:0]           out_kind,
  output logic                 out_write,
  output logic [5:0]           out_dev,
  output logic [15:0]          out_reg,
  output logic [7:0]           out_rd_cnt,
  output logic [3:0]           out_wr_len,
  output logic [8*WR_MAX-1:0]  out_payload,
  output logic                 err_crc,
  output logic                 err_init
);
  rx_state_e        state_q;
  logic [2:0]       kind_q;
  logic             wr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [5:0]       dev_q;
  logic [15:0]      ra_q;
  logic [7:0]       rd_q;
  logic [7:0]       lane_q [WR_MAX];
  logic             take;
  logic             reg_bad;

  assign in_ready  = !out_valid;
  assign take      = in_valid && in_ready && !in_idle;
  assign crc_take  = take;
  assign crc_first = (state_q == S_INIT);
  assign reg_bad   = 32'(ra_q) >= REG_SPAN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_INIT;
      kind_q    <= '0;
      wr_q      <= 1'b0;
      len_q     <= '0;
      idx_q     <= '0;
      dev_q     <= '0;
      ra_q      <= '0;
      rd_q      <= '0;
      out_valid <= 1'b0;
      err_crc   <= 1'b0;
      err_init  <= 1'b0;
    end else begin
      err_crc  <= 1'b0;
      err_init <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_idle) begin
        state_q <= S_INIT;
      end else if (take) begin
        unique case (state_q)
          S_INIT: begin
            if (!info.ok) begin
              err_init <= 1'b1;
              state_q  <= S_SKIP;
            end else begin
              kind_q  <= info.kind;
              wr_q    <= info.is_write;
              len_q   <= info.len_m1;
              dev_q   <= '0;
              rd_q    <= '0;
              idx_q   <= '0;
              state_q <= info.has_dev ? S_DEV : S_RA_HI;
            end
          end
          S_DEV: begin
            dev_q   <= (in_data[7:6] != 2'b00) ? DEV_TOP : in_data[5:0];
            state_q <= S_RA_HI;
          end
          S_RA_HI: begin
            ra_q[15:8] <= in_data;
            state_q    <= S_RA_LO;
          end
          S_RA_LO: begin
            ra_q[7:0] <= in_data;
            state_q   <= S_DATA;
          end
          S_DATA: begin
            if (wr_q) begin
              idx_q <= idx_q + 1'b1;
              if (idx_q == len_q) state_q <= S_CRC_LO;
            end else begin
              rd_q    <= {1'b0, in_data[6:0]} + 8'd1;
              state_q <= S_CRC_LO;
            end
          end
          S_CRC_LO: state_q <= S_CRC_HI;
          S_CRC_HI: begin
            state_q <= S_INIT;
            if (crc_nx != 16'h0000) err_crc <= 1'b1;
            else if (!(wr_q && reg_bad)) out_valid <= 1'b1;
          end
          default: state_q <= S_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WR_MAX; i++) lane_q[i] <= '0;
    end else if (take && !in_idle) begin
      for (int i = 0; i < WR_MAX; i++) begin
        if (state_q == S_INIT) lane_q[i] <= '0;
        else if (state_q == S_DATA && wr_q && idx_q == LEN_W'(i)) lane_q[i] <= in_data;
      end
    end
  end

  for (genvar g = 0; g < WR_MAX; g++) begin : g_lane
    assign out_payload[8*g +: 8] = lane_q[g];
  end

  assign out_kind   = kind_q;
  assign out_write  = wr_q;
  assign out_dev    = dev_q;
  assign out_reg    = ra_q;
  assign out_rd_cnt = rd_q;
  assign out_wr_len = wr_q ? ({1'b0, len_q} + 4'd1) : 4'd0;

  // R11: a stalled frame holds every field and the parser does not move
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_reg) && $stable(out_payload)
      && $stable(out_dev) && $stable(state_q)) else $error("stalled frame changed");
  // R7: at most one outcome per frame end
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_crc, err_init, $rose(out_valid)})) else $error("two outcomes at once");
  // R3: commands without an address byte report device 0
  assert_no_dev_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind[2:1] != 2'b00 |-> out_dev == 6'd0) else $error("device on non-single");
  // R4: read count lies in 1..128
  assert_rd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_write |-> out_rd_cnt != 8'd0 && out_rd_cnt <= 8'd128)
    else $error("read count out of range");
  // R10: an offered write always targets a valid register
  assert_wr_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write |-> 32'(out_reg) < REG_SPAN) else $error("write to invalid register offered");
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cfr_pkg::*;
#(
  parameter int unsigned REG_SPAN = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_idle,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_kind,
  output logic        out_write,
  output logic [5:0]  out_dev,
  output logic [15:0] out_reg,
  output logic [7:0]  out_rd_cnt,
  output logic [3:0]  out_wr_len,
  output logic [63:0] out_payload,
  output logic        err_crc,
  output logic        err_init
);
  init_info_t  info;
  logic [15:0] crc_nx;
  logic        crc_take;
  logic        crc_first;

  cfr_init_decode u_dec (
    .mark   (in_data[7]),
    .kind   (in_data[6:4]),
    .len_m1 (in_data[LEN_W-1:0]),
    .info   (info)
  );

  cfr_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (crc_take),
    .first   (crc_first),
    .byte_in (in_data),
    .crc_nx  (crc_nx)
  );

  cfr_parser #(.REG_SPAN(REG_SPAN)) u_parse (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_idle     (in_idle),
    .out_ready   (out_ready),
    .info        (info),
    .crc_nx      (crc_nx),
    .in_ready    (in_ready),
    .crc_take    (crc_take),
    .crc_first   (crc_first),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_write   (out_write),
    .out_dev     (out_dev),
    .out_reg     (out_reg),
    .out_rd_cnt  (out_rd_cnt),
    .out_wr_len  (out_wr_len),
    .out_payload (out_payload),
    .err_crc     (err_crc),
    .err_init    (err_init)
  );
endmodule

// File: tb/test_cmd_frame_rx.sv
module test_cmd_frame_rx;
  localparam int unsigned SPAN = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_idle = 1'b0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_write, err_crc, err_init;
  logic [2:0]  out_kind;
  logic [5:0]  out_dev;
  logic [15:0] out_reg;
  logic [7:0]  out_rd_cnt;
  logic [3:0]  out_wr_len;
  logic [63:0] out_payload;

  cmd_frame_rx #(.REG_SPAN(SPAN)) i_cmd_frame_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_idle(in_idle), .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_write(out_write), .out_dev(out_dev), .out_reg(out_reg), .out_rd_cnt(out_rd_cnt),
    .out_wr_len(out_wr_len), .out_payload(out_payload), .err_crc(err_crc), .err_init(err_init)
  );

  int n_tests = 0, n_fail = 0;
  int n_out = 0, n_crc = 0, n_init = 0;
  logic [2:0]  c_kind;
  logic [5:0]  c_dev;
  logic [15:0] c_reg;
  logic [7:0]  c_rd;
  logic [3:0]  c_len;
  logic [63:0] c_pay;
  logic [7:0]  fb [0:15];
  int fn = 0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      c_kind = out_kind; c_dev = out_dev; c_reg = out_reg;
      c_rd = out_rd_cnt; c_len = out_wr_len; c_pay = out_payload;
      n_out++;
    end
    if (err_crc) n_crc++;
    if (err_init) n_init++;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  function automatic logic [63:0] pay_of(input logic [7:0] seed, input int wl);
    logic [63:0] p = '0;
    for (int i = 0; i < 8; i++) if (i < wl) p[8*i +: 8] = seed + 8'(i * 37);
    return p;
  endfunction

  task automatic add(input logic [7:0] b);
    fb[fn] = b;
    fn = fn + 1;
  endtask

  task automatic build(input logic [2:0] kind, input logic [7:0] dev, input logic [15:0] ra,
                       input logic [7:0] rdb, input int wl, input logic [7:0] seed, input logic b3);
    logic [15:0] c;
    logic [63:0] p;
    fn = 0;
    add({1'b1, kind, b3, kind[0] ? 3'(wl - 1) : 3'b110});
    if (kind[2:1] == 2'b00) add(dev);
    add(ra[15:8]);
    add(ra[7:0]);
    if (kind[0]) begin
      p = pay_of(seed, wl);
      for (int i = 0; i < wl; i++) add(p[8*i +: 8]);
    end else add(rdb);
    c = 16'hFFFF;
    for (int i = 0; i < fn; i++) c = crc_b(c, fb[i]);
    add(c[7:0]);
    add(c[15:8]);
  endtask

  task automatic put(input logic [7:0] b);
    logic ok;
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_data = b;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk); #2;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_all();
    for (int i = 0; i < fn; i++) put(fb[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_pulse();
    @(posedge clk); #2;
    in_idle = 1'b1;
    @(posedge clk); #2;
    in_idle = 1'b0;
  endtask

  task automatic expect_frame(input string req, input int base, input logic [2:0] kind,
                              input logic [5:0] dev, input logic [15:0] ra, input logic [7:0] rd,
                              input logic [3:0] wl, input logic [63:0] pay);
    chk(req, "frame count", 64'(n_out), 64'(base + 1));
    chk("R1", "kind", 64'(c_kind), 64'(kind));
    chk("R3", "device", 64'(c_dev), 64'(dev));
    chk("R2", "register", 64'(c_reg), 64'(ra));
    chk("R4", "read count", 64'(c_rd), 64'(rd));
    chk("R5", "write length", 64'(c_len), 64'(wl));
    chk("R5", "payload", c_pay, pay);
  endtask

  initial begin
    #(20 * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base, cb, ib;
    logic [7:0] d;
    logic [5:0] de;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R11", "reset in_ready", 64'(in_ready), 64'd1);
    chk("R11", "reset err flags", 64'({err_crc, err_init}), 64'd0);

    // R3/R2/R4: single read over every address byte
    for (int i = 0; i < 256; i++) begin
      d = 8'(i);
      de = (d[7:6] != 2'b00) ? 6'h3F : d[5:0];
      base = n_out;
      build(3'd0, d, {d, d ^ 8'h5A}, d, 0, 8'h00, 1'b0);
      send_all();
      expect_frame("R3", base, 3'd0, de, {d, d ^ 8'h5A}, {1'b0, d[6:0]} + 8'd1, 4'd0, 64'd0);
    end

    // R4: stack read over every count byte, no address byte
    for (int i = 0; i < 256; i++) begin
      d = 8'(i);
      base = n_out;
      build(3'd2, 8'h00, 16'h0123, d, 0, 8'h00, 1'b0);
      send_all();
      expect_frame("R4", base, 3'd2, 6'd0, 16'h0123, {1'b0, d[6:0]} + 8'd1, 4'd0, 64'd0);
    end

    // R4 example: 0x99 asks for 26 registers
    base = n_out;
    build(3'd4, 8'h00, 16'h0010, 8'h99, 0, 8'h00, 1'b0);
    send_all();
    expect_frame("R4", base, 3'd4, 6'd0, 16'h0010, 8'd26, 4'd0, 64'd0);

    // R5/R1: all write kinds and lengths, bit 3 toggled
    for (int k = 1; k <= 5; k += 2) begin
      for (int wl = 1; wl <= 8; wl++) begin
        base = n_out;
        build(3'(k), 8'h07, 16'h0100 + 16'(wl), 8'h00, wl, 8'(k * 16 + wl), 1'(wl));
        send_all();
        expect_frame("R5", base, 3'(k), (k == 1) ? 6'h07 : 6'h00, 16'h0100 + 16'(wl), 8'd0,
                     4'(wl), pay_of(8'(k * 16 + wl), wl));
      end
    end

    // R6/R7: every single-bit error after INIT is caught as a CRC fault
    for (int j = 1; j < 10; j++) begin
      for (int b = 0; b < 8; b++) begin
        base = n_out;
        cb = n_crc;
        build(3'd1, 8'h21, 16'h0040, 8'h00, 4, 8'hC3, 1'b0);
        fb[j] = fb[j] ^ (8'h01 << b);
        send_all();
        chk("R6", "crc fault on flip", 64'(n_crc), 64'(cb + 1));
        chk("R7", "no frame on flip", 64'(n_out), 64'(base));
      end
    end

    // R7: CRC is judged before register validity
    base = n_out;
    cb = n_crc;
    build(3'd1, 8'h01, 16'hFFFF, 8'h00, 2, 8'h10, 1'b0);
    fb[fn-1] = fb[fn-1] ^ 8'h40;
    send_all();
    chk("R7", "crc fault on bad-register write", 64'(n_crc), 64'(cb + 1));
    chk("R7", "no frame", 64'(n_out), 64'(base));

    // R10: invalid register writes dropped silently, reads still delivered
    base = n_out;
    cb = n_crc;
    ib = n_init;
    build(3'd1, 8'h01, 16'(SPAN), 8'h00, 3, 8'h20, 1'b0);
    send_all();
    build(3'd3, 8'h00, 16'hFFFF, 8'h00, 1, 8'h30, 1'b0);
    send_all();
    chk("R10", "invalid writes not offered", 64'(n_out), 64'(base));
    chk("R10", "no error flags", 64'(n_crc + n_init), 64'(cb + ib));
    base = n_out;
    build(3'd1, 8'h02, 16'(SPAN - 1), 8'h00, 3, 8'h20, 1'b0);
    send_all();
    expect_frame("R10", base, 3'd1, 6'h02, 16'(SPAN - 1), 8'd0, 4'd3, pay_of(8'h20, 3));
    base = n_out;
    build(3'd0, 8'h02, 16'hFFFF, 8'h05, 0, 8'h00, 1'b0);
    send_all();
    expect_frame("R10", base, 3'd0, 6'h02, 16'hFFFF, 8'd6, 4'd0, 64'd0);

    // R8: undecodable INIT discards until idle
    for (int t = 0; t < 3; t++) begin
      base = n_out;
      ib = n_init;
      cb = n_crc;
      put((t == 0) ? 8'h15 : (t == 1) ? 8'hE0 : 8'hF3);
      build(3'd2, 8'h00, 16'h0200, 8'h03, 0, 8'h00, 1'b0);
      send_all();
      chk("R8", "init fault", 64'(n_init), 64'(ib + 1));
      chk("R8", "bytes after bad INIT ignored", 64'(n_out), 64'(base));
      chk("R8", "no crc fault while skipping", 64'(n_crc), 64'(cb));
      idle_pulse();
      base = n_out;
      send_all();
      expect_frame("R8", base, 3'd2, 6'd0, 16'h0200, 8'd4, 4'd0, 64'd0);
    end

    // R9: idle gap inside a frame restarts the parser
    build(3'd0, 8'h11, 16'h0333, 8'h01, 0, 8'h00, 1'b0);
    put(fb[0]);
    put(fb[1]);
    put(fb[2]);
    idle_pulse();
    base = n_out;
    cb = n_crc;
    send_all();
    expect_frame("R9", base, 3'd0, 6'h11, 16'h0333, 8'd2, 4'd0, 64'd0);
    chk("R9", "no crc fault after gap", 64'(n_crc), 64'(cb));

    // R11: stalled consumer
    @(posedge clk); #2 out_ready = 1'b0;
    base = n_out;
    build(3'd3, 8'h00, 16'h0444, 8'h00, 5, 8'h77, 1'b0);
    send_all();
    repeat (4) @(negedge clk);
    chk("R11", "valid held", 64'(out_valid), 64'd1);
    chk("R11", "input blocked", 64'(in_ready), 64'd0);
    chk("R11", "register held", 64'(out_reg), 64'h0444);
    chk("R11", "payload held", out_payload, pay_of(8'h77, 5));
    chk("R11", "not taken while stalled", 64'(n_out), 64'(base));
    @(posedge clk); #2 out_ready = 1'b1;
    repeat (2) @(negedge clk);
    expect_frame("R11", base, 3'd3, 6'd0, 16'h0444, 8'd0, 4'd5, pay_of(8'h77, 5));
    chk("R11", "valid drops after handover", 64'(out_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule